// File: doc/BRIEF.md
# Configurable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port for a synchronous system. A transmitter turns a byte, plus an optional ninth bit, into a serial frame on `txd`. A receiver samples `rxd`, rebuilds each frame and queues the byte with its status in a small receive queue. The caller empties that queue with a pop strobe.

The frame shape comes from static configuration inputs:
- character size of 5 to 8 bits,
- an optional ninth slot that carries either a parity bit or a user bit,
- a short or long stop period,
- an address-filtering mode for multi-drop links.

Each direction has its own reload-style timer that restarts at the start of its frame. The timer ticks once per half bit. The half-bit length in clock cycles is P × (65536 − reload), where the prescale factor P is 1, 4, 12 or 48. The serial bit rate is therefore clk / (65536 − reload) / 2 / P. For example, a 48 MHz clock with P = 1 and reload 65120 gives a bit of about 57600 baud.

Top module: `cfg_uart`

## Requirements
- R1: While idle, `txd` is 1. An accepted write drives a 0 start bit from the next clock edge, followed by `cfg_len`+5 data bits (`cfg_len` 0..3 selects 5..8 bits), least significant bit first. Every bit lasts 2H clock cycles.
- R2: H = P × (65536 − `cfg_reload`) clock cycles. `cfg_presc` codes 0, 1, 2 and 3 select P = 1, 4, 12 and 48.
- R3: With `cfg_par_en`=1, a parity bit follows the data bits. `cfg_par_mode` selects the rule: 0 makes the count of ones in data plus parity odd, 1 makes it even, 2 always sends 1, 3 always sends 0.
- R4: With `cfg_par_en`=0 and `cfg_x9_en`=1, the slot after the data carries `tx_x9`. With `cfg_par_en`=1, `tx_x9` has no effect on the line. With both flags at 0, the frame has no ninth slot.
- R5: The stop level is 1. With `cfg_stop_long`=0 it lasts 2H. With `cfg_stop_long`=1 it lasts 3H for 5-bit data and 4H otherwise. `tx_busy` goes high at the write edge and falls at the end of the stop period. A write while `tx_busy` is high is ignored.
- R6: A received frame is confirmed at the centre of its start bit and sampled at the centre of each later bit. It then enters the queue. The oldest entry is shown on `rx_data` (upper unused bits 0) and `rx_x9` (the received ninth slot, 0 if there is none), with `rx_valid`=1. `rx_pop` removes that entry.
- R7: With parity enabled, `rx_perr` is 1 for an entry whose received parity bit differs from the rule in R3.
- R8: `rx_ferr` is 1 for an entry whose stop bit was sampled at 0.
- R9: The queue holds three entries. A frame that arrives while three entries are unread is dropped and sets `rx_ovf`. `rx_ovf` stays set until the next pop.
- R10: With `cfg_mp_en`=1, `cfg_x9_en`=1 and `cfg_par_en`=0, a received frame whose ninth bit is 0 is dropped without entering the queue. A frame whose ninth bit is 1 is queued.
- R11: After reset, `txd`=1, `tx_busy`=0, `rx_valid`=0 and `rx_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len | input | 2 | Character size code, size = code + 5 |
| cfg_par_en | input | 1 | Parity bit in the ninth slot |
| cfg_par_mode | input | 2 | Parity rule: odd, even, mark, space |
| cfg_x9_en | input | 1 | User ninth bit when parity is off |
| cfg_stop_long | input | 1 | Long stop period |
| cfg_mp_en | input | 1 | Drop received frames whose ninth bit is 0 |
| cfg_presc | input | 2 | Prescale select: 1, 4, 12, 48 |
| cfg_reload | input | 16 | Timer reload value |
| tx_wr | input | 1 | Write strobe for a new frame |
| tx_data | input | 8 | Byte to send |
| tx_x9 | input | 1 | Ninth bit to send |
| tx_busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_pop | input | 1 | Remove the oldest queue entry |
| rx_valid | output | 1 | Queue not empty |
| rx_data | output | 8 | Oldest received byte |
| rx_x9 | output | 1 | Ninth bit of the oldest entry |
| rx_ferr | output | 1 | Framing error of the oldest entry |
| rx_perr | output | 1 | Parity error of the oldest entry |
| rx_ovf | output | 1 | A frame was lost to a full queue |

## Verification
The assertions check the following on every cycle:
- the idle-high line,
- a start bit coinciding with the rise of `tx_busy`,
- that `tx_busy` never rises without a write,
- that the overflow flag persists until a pop,
- that the head entry of the queue holds steady while unpopped.

Only the bench scenarios can show the bit timing for each prescale code, the parity and ninth-bit values, the stop lengths, and the error flags. The same applies to dropping frames on a full queue or on a ninth bit of 0. The bench observes these by sampling the line at bit centres, by looping the transmitter back into the receiver, and by driving hand-made faulty frames.

// File: rtl/cfg_uart_pkg.sv
// Shared types and helpers for the configurable serial port.
// Assumes characters of at most 8 bits and a 16-bit reload timer.
package cfg_uart_pkg;

    localparam int DATA_W   = 8;
    localparam int RELOAD_W = 16;
    localparam int PRE_W    = 6;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'd0,
        PAR_EVEN  = 2'd1,
        PAR_MARK  = 2'd2,
        PAR_SPACE = 2'd3
    } par_mode_e;

    typedef struct packed {
        logic              perr;
        logic              ferr;
        logic              x9;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Number of data bits for a size code.
    function automatic logic [3:0] data_bits(input logic [1:0] len);
        return {2'b00, len} + 4'd5;
    endfunction

    // Mask of the data bits in use for a size code.
    function automatic logic [DATA_W-1:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    // Parity bit for the used data bits under a rule.
    function automatic logic par_bit(input logic [DATA_W-1:0] d,
                                     input logic [1:0]        len,
                                     input par_mode_e         mode);
        logic [DATA_W-1:0] md;
        md = d & len_mask(len);
        case (mode)
            PAR_ODD:  return ~(^md);
            PAR_EVEN: return ^md;
            PAR_MARK: return 1'b1;
            default:  return 1'b0;
        endcase
    endfunction

    // Last value of the prescale counter for a select code.
    function automatic logic [PRE_W-1:0] presc_last(input logic [1:0] sel);
        case (sel)
            2'd0:    return 6'd0;
            2'd1:    return 6'd3;
            2'd2:    return 6'd11;
            default: return 6'd47;
        endcase
    endfunction

endpackage

// File: rtl/cfg_uart_baud.sv
// Half-bit timer: a prescaler feeding a 16-bit up-counter that reloads on
// overflow. One tick every P*(65536-reload) cycles after a restart.
// Assumes the configuration is held steady while a frame is in flight.
module cfg_uart_baud
    import cfg_uart_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic [1:0]          presc_sel,
    input  logic [RELOAD_W-1:0] reload,
    output logic                tick
);

    logic [PRE_W-1:0]    pre_q;
    logic [RELOAD_W-1:0] tmr_q;
    logic [PRE_W-1:0]    pre_last;
    logic                pre_wrap;

    assign pre_last = presc_last(presc_sel);
    assign pre_wrap = (pre_q == pre_last);
    assign tick     = !restart && pre_wrap && (tmr_q == {RELOAD_W{1'b1}});

    // Advance the prescaler and the reload timer, or realign on restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            tmr_q <= '0;
        end else if (restart) begin
            pre_q <= '0;
            tmr_q <= reload;
        end else if (pre_wrap) begin
            pre_q <= '0;
            tmr_q <= (tmr_q == {RELOAD_W{1'b1}}) ? reload : tmr_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/cfg_uart_tx.sv
// Transmit serialiser: builds the whole frame in a shift register at the
// write and moves one bit every two half-bit ticks, counting half bits so
// that 1.5-bit stop periods come out exact.
// Assumes the tick source restarts on the same edge that loads a frame.
module cfg_uart_tx
    import cfg_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        len,
    input  logic              par_en,
    input  par_mode_e         par_mode,
    input  logic              x9_en,
    input  logic              stop_long,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] data,
    input  logic              x9,
    output logic              load,
    output logic              busy,
    output logic              txd
);

    localparam int SR_W = DATA_W + 4;
    localparam int HC_W = 5;

    logic [SR_W-1:0] sr_q;
    logic [SR_W-1:0] frame;
    logic [HC_W-1:0] hcnt_q;
    logic [HC_W-1:0] halves;
    logic [HC_W-1:0] stop_h;
    logic [3:0]      nd;
    logic [3:0]      nbits;
    logic            slot;
    logic            ph_q;
    logic            busy_q;

    assign nd     = data_bits(len);
    assign slot   = par_en | x9_en;
    assign load   = wr && !busy_q;
    assign busy   = busy_q;
    assign txd    = sr_q[0];
    assign stop_h = !stop_long ? 5'd2 : ((len == 2'd0) ? 5'd3 : 5'd4);
    assign nbits  = 4'd1 + nd + {3'b000, slot};
    assign halves = {nbits, 1'b0} + stop_h;

    // Assemble start bit, data, optional ninth slot and idle-level tail.
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < int'(nd)) frame[i+1] = data[i];
        end
        if (slot) frame[int'(nd)+1] = par_en ? par_bit(data, len, par_mode) : x9;
    end

    // Load on write, shift every second tick, end after the stop period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q   <= '1;
            busy_q <= 1'b0;
            hcnt_q <= '0;
            ph_q   <= 1'b0;
        end else if (load) begin
            sr_q   <= frame;
            busy_q <= 1'b1;
            hcnt_q <= halves;
            ph_q   <= 1'b0;
        end else if (busy_q && tick) begin
            ph_q   <= ~ph_q;
            if (ph_q) sr_q <= {1'b1, sr_q[SR_W-1:1]};
            hcnt_q <= hcnt_q - 1'b1;
            if (hcnt_q == 5'd1) busy_q <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_uart_rx.sv
// Receive deserialiser: synchronises the line, restarts its timer at a
// falling edge, confirms the start bit half a bit later, then samples each
// following bit centre. Emits one push per kept frame with its status.
// Assumes the line idles high and the configuration is held per frame.
module cfg_uart_rx
    import cfg_uart_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] len,
    input  logic      par_en,
    input  par_mode_e par_mode,
    input  logic      x9_en,
    input  logic      mp_en,
    input  logic      tick,
    input  logic      rxd,
    output logic      restart,
    output logic      push,
    output rx_entry_t entry
);

    typedef enum logic [1:0] {RS_IDLE, RS_START, RS_BITS} rx_state_e;

    rx_state_e         state_q;
    logic              s1_q, s2_q;
    logic [3:0]        idx_q;
    logic              ph_q;
    logic [DATA_W-1:0] shreg_q;
    logic              x9_q;
    logic [3:0]        nd;
    logic [3:0]        last_idx;
    logic              slot;
    logic              perr;
    logic              keep;

    assign nd       = data_bits(len);
    assign slot     = par_en | x9_en;
    assign last_idx = nd + {3'b000, slot};
    assign restart  = (state_q == RS_IDLE) && !s2_q;
    assign perr     = par_en && (x9_q != par_bit(shreg_q, len, par_mode));
    assign keep     = !(mp_en && !par_en && x9_en && !x9_q);

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
        end
    end

    // Frame sequencing, bit capture and queue push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            idx_q   <= '0;
            ph_q    <= 1'b0;
            shreg_q <= '0;
            x9_q    <= 1'b0;
            push    <= 1'b0;
            entry   <= '0;
        end else begin
            push <= 1'b0;
            case (state_q)
                RS_IDLE: if (!s2_q) state_q <= RS_START;
                RS_START: if (tick) begin
                    if (!s2_q) begin
                        state_q <= RS_BITS;
                        idx_q   <= '0;
                        ph_q    <= 1'b0;
                        shreg_q <= '0;
                        x9_q    <= 1'b0;
                    end else begin
                        state_q <= RS_IDLE;
                    end
                end
                default: if (tick) begin
                    ph_q <= ~ph_q;
                    if (ph_q) begin
                        idx_q <= idx_q + 1'b1;
                        if (idx_q < nd) begin
                            shreg_q[idx_q[2:0]] <= s2_q;
                        end else if (idx_q != last_idx) begin
                            x9_q <= s2_q;
                        end else begin
                            state_q    <= RS_IDLE;
                            push       <= keep;
                            entry.data <= shreg_q;
                            entry.x9   <= x9_q;
                            entry.ferr <= !s2_q;
                            entry.perr <= perr;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cfg_uart_fifo.sv
// Small receive queue of any depth with a sticky loss flag.
// Assumes push and pop are single-cycle strobes; a pop frees room for a
// push in the same cycle.
module cfg_uart_fifo #(
    parameter int DEPTH = 3,
    parameter int W     = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic         valid,
    output logic [W-1:0] rdata,
    output logic         ovf
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [PW-1:0] rp_q, wp_q;
    logic [CW-1:0] cnt_q;
    logic          full, do_pop, do_push;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);
    assign do_push = push && (!full || do_pop);
    assign valid   = (cnt_q != '0);
    assign rdata   = mem_q[rp_q];

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wp_q] <= wdata;
    end

    // Pointers, occupancy and loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q  <= '0;
            wp_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wp_q <= nxt(wp_q);
            if (do_pop)  rp_q <= nxt(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
            if (push && !do_push) ovf <= 1'b1;
            else if (do_pop)      ovf <= 1'b0;
        end
    end

endmodule

// File: rtl/cfg_uart.sv
// Top of the serial port: two restartable half-bit timers, transmitter,
// receiver and receive queue. Assumes configuration changes only while
// both directions are idle.
module cfg_uart
    import cfg_uart_pkg::*;
#(
    parameter int FIFO_DEPTH = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_par_en,
    input  logic [1:0]  cfg_par_mode,
    input  logic        cfg_x9_en,
    input  logic        cfg_stop_long,
    input  logic        cfg_mp_en,
    input  logic [1:0]  cfg_presc,
    input  logic [15:0] cfg_reload,
    input  logic        tx_wr,
    input  logic [7:0]  tx_data,
    input  logic        tx_x9,
    output logic        tx_busy,
    output logic        txd,
    input  logic        rxd,
    input  logic        rx_pop,
    output logic        rx_valid,
    output logic [7:0]  rx_data,
    output logic        rx_x9,
    output logic        rx_ferr,
    output logic        rx_perr,
    output logic        rx_ovf
);

    localparam int ENTRY_W = $bits(rx_entry_t);

    par_mode_e pmode;
    logic      tx_load, tx_tick, rx_restart, rx_tick, rx_push;
    rx_entry_t rx_entry, head;
    logic [ENTRY_W-1:0] head_bits;

    assign pmode = par_mode_e'(cfg_par_mode);

    cfg_uart_baud tx_baud_i (
        .clk(clk), .rst_n(rst_n), .restart(tx_load),
        .presc_sel(cfg_presc), .reload(cfg_reload), .tick(tx_tick)
    );

    cfg_uart_baud rx_baud_i (
        .clk(clk), .rst_n(rst_n), .restart(rx_restart),
        .presc_sel(cfg_presc), .reload(cfg_reload), .tick(rx_tick)
    );

    cfg_uart_tx tx_i (
        .clk(clk), .rst_n(rst_n), .len(cfg_len), .par_en(cfg_par_en),
        .par_mode(pmode), .x9_en(cfg_x9_en), .stop_long(cfg_stop_long),
        .tick(tx_tick), .wr(tx_wr), .data(tx_data), .x9(tx_x9),
        .load(tx_load), .busy(tx_busy), .txd(txd)
    );

    cfg_uart_rx rx_i (
        .clk(clk), .rst_n(rst_n), .len(cfg_len), .par_en(cfg_par_en),
        .par_mode(pmode), .x9_en(cfg_x9_en), .mp_en(cfg_mp_en),
        .tick(rx_tick), .rxd(rxd), .restart(rx_restart),
        .push(rx_push), .entry(rx_entry)
    );

    cfg_uart_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_entry),
        .pop(rx_pop), .valid(rx_valid), .rdata(head_bits), .ovf(rx_ovf)
    );

    assign head    = rx_entry_t'(head_bits);
    assign rx_data = head.data;
    assign rx_x9   = head.x9;
    assign rx_ferr = head.ferr;
    assign rx_perr = head.perr;

endmodule

// File: rtl/cfg_uart_chk.sv
// Cycle-level properties of the serial port, attached to the top by bind.
// Assumes the synchronous active-low reset of the design.
module cfg_uart_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       txd,
    input logic       tx_busy,
    input logic       tx_wr,
    input logic       rx_valid,
    input logic       rx_pop,
    input logic [7:0] rx_data,
    input logic       rx_ovf
);

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);                                            // R1

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !txd);                                     // R1

    AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_busy && !tx_wr) |=> !tx_busy);                           // R5

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovf && !rx_pop) |=> rx_ovf);                              // R9

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_pop) |=> (rx_valid && $stable(rx_data)));    // R6

endmodule

bind cfg_uart cfg_uart_chk chk_i (
    .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy), .tx_wr(tx_wr),
    .rx_valid(rx_valid), .rx_pop(rx_pop), .rx_data(rx_data), .rx_ovf(rx_ovf)
);

// File: tb/cfg_uart_tb_top.sv
// Self-checking bench: a frame table walked in loopback, then directed
// tests for prescaling, ignored writes, filtering, errors and overflow.
module cfg_uart_tb_top;

    localparam int CLK_PERIOD = 10;

    // Fields: len[15:14] par_en[13] par_mode[12:11] x9_en[10] stop_long[9] data[8:1] x9[0]
    localparam logic [15:0] VEC [7] = '{
        {2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 8'hA5, 1'b0},
        {2'd0, 1'b0, 2'd0, 1'b0, 1'b1, 8'h1B, 1'b0},
        {2'd1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h2D, 1'b1},
        {2'd2, 1'b1, 2'd1, 1'b0, 1'b1, 8'h55, 1'b0},
        {2'd3, 1'b1, 2'd2, 1'b0, 1'b0, 8'h00, 1'b0},
        {2'd3, 1'b1, 2'd3, 1'b0, 1'b0, 8'hFF, 1'b0},
        {2'd3, 1'b0, 2'd0, 1'b1, 1'b0, 8'h3C, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic [1:0]  cfg_par_mode = 2'd0;
    logic        cfg_x9_en = 1'b0;
    logic        cfg_stop_long = 1'b0;
    logic        cfg_mp_en = 1'b0;
    logic [1:0]  cfg_presc = 2'd0;
    logic [15:0] cfg_reload = 16'd65528;
    logic        tx_wr = 1'b0;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_x9 = 1'b0;
    logic        tx_busy, txd, rxd;
    logic        rx_pop = 1'b0;
    logic        rx_valid, rx_x9, rx_ferr, rx_perr, rx_ovf;
    logic [7:0]  rx_data;
    logic        loop_en = 1'b1;
    logic        rx_drv = 1'b1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    assign rxd = loop_en ? txd : rx_drv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cfg_uart dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_mode(cfg_par_mode), .cfg_x9_en(cfg_x9_en),
        .cfg_stop_long(cfg_stop_long), .cfg_mp_en(cfg_mp_en),
        .cfg_presc(cfg_presc), .cfg_reload(cfg_reload), .tx_wr(tx_wr),
        .tx_data(tx_data), .tx_x9(tx_x9), .tx_busy(tx_busy), .txd(txd),
        .rxd(rxd), .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_x9(rx_x9), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovf(rx_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int half_cycles(input logic [1:0] ps, input logic [15:0] rl);
        int p;
        case (ps)
            2'd0:    p = 1;
            2'd1:    p = 4;
            2'd2:    p = 12;
            default: p = 48;
        endcase
        return p * (65536 - int'(rl));
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int nd, input logic [1:0] pm);
        int ones = 0;
        for (int i = 0; i < nd; i++) ones += int'(d[i]);
        case (pm)
            2'd0:    return (ones % 2 == 0);
            2'd1:    return (ones % 2 == 1);
            2'd2:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_cfg(input logic [1:0] len, input logic pe, input logic [1:0] pm,
                           input logic xe, input logic sl, input logic mp,
                           input logic [1:0] ps, input logic [15:0] rl);
        @(negedge clk);
        cfg_len = len; cfg_par_en = pe; cfg_par_mode = pm; cfg_x9_en = xe;
        cfg_stop_long = sl; cfg_mp_en = mp; cfg_presc = ps; cfg_reload = rl;
    endtask

    task automatic pop_one();
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
        @(negedge clk);
    endtask

    // Send one frame, check every bit centre, busy length and loopback result.
    task automatic tx_frame_check(input string req, input logic [7:0] d,
                                  input logic x, input bit extra_wr);
        int h, nd, slot, nb, stoph, wait_n;
        logic sv, expb, keep;
        logic [7:0] msk;
        h     = half_cycles(cfg_presc, cfg_reload);
        nd    = int'(cfg_len) + 5;
        slot  = (cfg_par_en || cfg_x9_en) ? 1 : 0;
        sv    = cfg_par_en ? exp_par(d, nd, cfg_par_mode) : (cfg_x9_en ? x : 1'b0);
        stoph = !cfg_stop_long ? 2 : ((nd == 5) ? 3 : 4);
        nb    = nd + slot + 2;
        msk   = 8'hFF >> (8 - nd);
        keep  = !(cfg_mp_en && !cfg_par_en && cfg_x9_en && !x);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_x9 = x;
        @(negedge clk);
        tx_wr = 1'b0;
        chk({req, " busy at start"}, int'(tx_busy), 1);
        repeat (h) @(negedge clk);
        chk({req, " start bit"}, int'(txd), 0);
        wait_n = 2 * h;
        if (extra_wr) begin
            tx_wr = 1'b1; tx_data = ~d; tx_x9 = ~x;
            @(negedge clk);
            tx_wr = 1'b0;
            wait_n = 2 * h - 1;
        end
        for (int k = 1; k < nb; k++) begin
            repeat (wait_n) @(negedge clk);
            wait_n = 2 * h;
            if (k <= nd)                     expb = d[k-1];
            else if (slot == 1 && k == nd + 1) expb = sv;
            else                             expb = 1'b1;
            chk({req, " line bit"}, int'(txd), int'(expb));
        end
        repeat (h * (stoph - 1) - 1) @(negedge clk);
        chk({req, " busy before stop end"}, int'(tx_busy), 1);
        @(negedge clk);
        chk({req, " busy after stop end"}, int'(tx_busy), 0);
        if (loop_en) begin
            repeat (3) @(negedge clk);
            if (keep) begin
                chk({req, " R6 valid"}, int'(rx_valid), 1);
                chk({req, " R6 data"}, int'(rx_data), int'(d & msk));
                chk({req, " R6 ninth"}, int'(rx_x9), int'(sv));
                chk({req, " R8 ferr"}, int'(rx_ferr), 0);
                chk({req, " R7 perr"}, int'(rx_perr), 0);
                pop_one();
            end
            chk({req, " queue empty"}, int'(rx_valid), 0);
        end
    endtask

    // Drive a hand-made frame on the receive line.
    task automatic rx_send(input logic [7:0] d, input int nd, input bit has_slot,
                           input logic sv, input logic stopv);
        int h;
        h = half_cycles(cfg_presc, cfg_reload);
        @(negedge clk);
        rx_drv = 1'b0;
        repeat (2 * h) @(negedge clk);
        for (int i = 0; i < nd; i++) begin
            rx_drv = d[i];
            repeat (2 * h) @(negedge clk);
        end
        if (has_slot) begin
            rx_drv = sv;
            repeat (2 * h) @(negedge clk);
        end
        rx_drv = stopv;
        repeat (2 * h) @(negedge clk);
        rx_drv = 1'b1;
        repeat (4 * h) @(negedge clk);
    endtask

    task automatic tx_send(input logic [7:0] d);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = d; tx_x9 = 1'b0;
        @(negedge clk);
        tx_wr = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 txd", int'(txd), 1);
        chk("R11 tx_busy", int'(tx_busy), 0);
        chk("R11 rx_valid", int'(rx_valid), 0);
        chk("R11 rx_ovf", int'(rx_ovf), 0);

        // Table walk in loopback: R1 R3 R4 R5 R6
        for (int v = 0; v < 7; v++) begin
            set_cfg(VEC[v][15:14], VEC[v][13], VEC[v][12:11], VEC[v][10], VEC[v][9],
                    1'b0, 2'd0, 16'd65528);
            tx_frame_check("R1/R3/R4/R5", VEC[v][8:1], VEC[v][0], 1'b0);
        end

        // R2: each prescale code, and the 57600-baud setting at 48 MHz
        for (int p = 1; p < 4; p++) begin
            set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'(p), 16'd65535);
            tx_frame_check("R2", 8'h96, 1'b0, 1'b0);
        end
        set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'd65120);
        tx_frame_check("R2", 8'h5A, 1'b0, 1'b0);

        // R5: write during a frame is ignored
        set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'd65528);
        tx_frame_check("R5 ignored write", 8'hC3, 1'b0, 1'b1);

        // R10: address filtering on the ninth bit
        set_cfg(2'd3, 1'b0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 16'd65528);
        tx_frame_check("R10 dropped", 8'h41, 1'b0, 1'b0);
        tx_frame_check("R10 kept", 8'h42, 1'b1, 1'b0);

        // R7: parity error on a hand-made frame (even rule, 0x07 needs 1)
        loop_en = 1'b0;
        set_cfg(2'd3, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 16'd65528);
        rx_send(8'h07, 8, 1'b1, 1'b0, 1'b1);
        chk("R7 valid", int'(rx_valid), 1);
        chk("R7 data", int'(rx_data), 7);
        chk("R7 perr set", int'(rx_perr), 1);
        chk("R7 ferr clear", int'(rx_ferr), 0);
        pop_one();
        rx_send(8'h07, 8, 1'b1, 1'b1, 1'b1);
        chk("R7 perr clear", int'(rx_perr), 0);
        pop_one();

        // R8: stop bit sampled low
        set_cfg(2'd3, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 16'd65528);
        rx_send(8'h81, 8, 1'b0, 1'b0, 1'b0);
        chk("R8 valid", int'(rx_valid), 1);
        chk("R8 ferr set", int'(rx_ferr), 1);
        chk("R8 data", int'(rx_data), 129);
        pop_one();
        chk("R8 queue empty", int'(rx_valid), 0);

        // R9: fourth unread frame is lost
        loop_en = 1'b1;
        tx_send(8'h11);
        tx_send(8'h22);
        tx_send(8'h33);
        chk("R9 no loss yet", int'(rx_ovf), 0);
        tx_send(8'h44);
        chk("R9 ovf set", int'(rx_ovf), 1);
        chk("R9 head first", int'(rx_data), 17);
        pop_one();
        chk("R9 ovf cleared", int'(rx_ovf), 0);
        chk("R9 second", int'(rx_data), 34);
        pop_one();
        chk("R9 third", int'(rx_data), 51);
        pop_one();
        chk("R9 fourth lost", int'(rx_valid), 0);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule